// File: doc/BRIEF.md
# Interrupt Running Priority Tracker

This block follows the priorities of the interrupts that a CPU interface has taken and not yet priority-dropped. From these it produces the running priority as a 64-bit read value. Each acknowledge event brings the 8-bit priority of the interrupt being taken. Each priority-drop event retires the most urgent entry that is still running. A numerically lower value means a more urgent interrupt.

The block does not report the raw priority. It reports the group priority, computed as if the binary point were at its minimum. Bit 0 always reads as zero, and so do the unimplemented low bits when fewer than 8 priority bits are configured. When nothing is running, the read value is the idle code 0xFF. This includes the case where every taken interrupt has been dropped but not yet deactivated. The read value is registered. It reflects the events of a cycle from the following cycle onward.

Top module: `rpr_tracker`

## Requirements
- R1: Bits 63..8 of `rpr_value` always read as zero.
- R2: When no acknowledged, not-yet-dropped entry exists, `rpr_value[7:0]` is the idle code 0xFF.
- R3: After an acknowledge, `rpr_value[7:0]` from the next cycle on is the smallest group priority among all running entries.
- R4: The group priority is the masked priority with bit 0 forced to zero. The index of a running entry is bits [7:1] of the masked priority.
- R5: With `impl_bits` = N, the low 8−N priority bits are cleared before grouping. N is taken as 5 when below 5 and as 8 when above 8. The read value for N=8 is a normal group priority, so it does not expose N.
- R6: A priority drop removes the running entry with the smallest group priority. Once all entries are dropped the value is 0xFF, even if the interrupts were never deactivated.
- R7: When an acknowledge and a drop occur in the same cycle, the drop acts on the old set first, and then the acknowledged entry is added.
- R8: A deactivate event has no effect on `rpr_value`.
- R9: A drop while nothing is running has no effect.
- R10: Synchronous reset empties the running set, so `rpr_value` reads 0xFF on the cycle after reset.
- R11: Two acknowledges with the same group priority occupy one entry, and one drop removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_valid | input | 1 | An interrupt is taken this cycle |
| ack_prio | input | 8 | Priority of the taken interrupt |
| drop_valid | input | 1 | Priority drop this cycle |
| deact_valid | input | 1 | Deactivate event (no effect on the value) |
| impl_bits | input | 4 | Number of implemented priority bits (5..8) |
| rpr_value | output | 64 | Running priority read value |

## Verification
The bench first stacks acknowledges out of priority order. The value follows the minimum and not the most recent entry, which separates a true minimum from a last-in tracker. Drops then peel entries off in ascending order, down to idle. This separates dropping from deactivating, and a priority of 0xFE from the idle code. Same-cycle acknowledge-plus-drop and duplicate-level patterns expose the wrong event order and per-interrupt counting. Acknowledges at each implemented-bit setting, including out-of-range settings, show the masking and the clamping.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  // Clamp a configured count of implemented priority bits into [lo, hi].
  function automatic int clamp_bits(input int cfg, input int lo, input int hi);
    if (cfg < lo) return lo;
    if (cfg > hi) return hi;
    return cfg;
  endfunction
endpackage

// File: rtl/rpt_prio_mask.sv
module rpt_prio_mask #(
  parameter int PRIO_W   = 8,
  parameter int MIN_BITS = 5,
  localparam int CFG_W   = $clog2(PRIO_W + 1),
  localparam int LVL_W   = PRIO_W - 1
) (
  input  logic [PRIO_W-1:0] prio,
  input  logic [CFG_W-1:0]  cfg,
  output logic [LVL_W-1:0]  level
);
  logic [PRIO_W-1:0] keep;
  logic [PRIO_W-1:0] masked;
  int                nbits;

  always_comb begin
    nbits = rpt_pkg::clamp_bits(int'(cfg), MIN_BITS, PRIO_W);
    for (int i = 0; i < PRIO_W; i++) keep[i] = (i >= PRIO_W - nbits);
    masked = prio & keep;
  end

  assign level = masked[PRIO_W-1:1];
endmodule

// File: rtl/rpt_lowest_find.sv
module rpt_lowest_find #(
  parameter int LEVELS = 128,
  localparam int IDX_W = $clog2(LEVELS)
) (
  input  logic [LEVELS-1:0] map,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (map[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rpt_active_map.sv
module rpt_active_map #(
  parameter int LEVELS = 128,
  localparam int IDX_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack,
  input  logic [IDX_W-1:0]  ack_lvl,
  input  logic              drop,
  output logic [LEVELS-1:0] map_q,
  output logic [LEVELS-1:0] map_d
);
  logic             cur_found;
  logic [IDX_W-1:0] cur_idx;

  rpt_lowest_find #(.LEVELS(LEVELS)) u_cur_find (
    .map(map_q), .found(cur_found), .idx(cur_idx)
  );

  // Drop acts on the old set first, then the acknowledge is merged in (R7).
  always_comb begin
    map_d = map_q;
    if (drop && cur_found) map_d[cur_idx] = 1'b0;
    if (ack) map_d[ack_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) map_q <= '0;
    else     map_q <= map_d;
  end

  // R7: an acknowledged level is present next cycle, even with a same-cycle drop
  a_r7_ack_survives_drop: assert property (@(posedge clk) disable iff (rst)
    ack |=> map_q[$past(ack_lvl)]);

  // R9: dropping with an empty set leaves it empty
  a_r9_drop_on_empty: assert property (@(posedge clk) disable iff (rst)
    (drop && !ack && map_q == '0) |=> map_q == '0);
endmodule

// File: rtl/rpr_tracker.sv
module rpr_tracker #(
  parameter int PRIO_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int OUT_W    = 64,
  localparam int CFG_W   = $clog2(PRIO_W + 1),
  localparam int LEVELS  = 2 ** (PRIO_W - 1),
  localparam int IDX_W   = PRIO_W - 1,
  localparam logic [PRIO_W-1:0] IDLE = {PRIO_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_valid,
  input  logic [PRIO_W-1:0] ack_prio,
  input  logic              drop_valid,
  input  logic              deact_valid,
  input  logic [CFG_W-1:0]  impl_bits,
  output logic [OUT_W-1:0]  rpr_value
);
  logic [IDX_W-1:0]  ack_lvl;
  logic [LEVELS-1:0] map_q;
  logic [LEVELS-1:0] map_d;
  logic              nxt_found;
  logic [IDX_W-1:0]  nxt_idx;
  logic [OUT_W-1:0]  rpr_q;

  rpt_prio_mask #(.PRIO_W(PRIO_W), .MIN_BITS(MIN_BITS)) u_mask (
    .prio(ack_prio), .cfg(impl_bits), .level(ack_lvl)
  );

  rpt_active_map #(.LEVELS(LEVELS)) u_map (
    .clk(clk), .rst(rst), .ack(ack_valid), .ack_lvl(ack_lvl),
    .drop(drop_valid), .map_q(map_q), .map_d(map_d)
  );

  rpt_lowest_find #(.LEVELS(LEVELS)) u_nxt_find (
    .map(map_d), .found(nxt_found), .idx(nxt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) rpr_q <= {{(OUT_W-PRIO_W){1'b0}}, IDLE};
    else if (nxt_found) rpr_q <= {{(OUT_W-PRIO_W){1'b0}}, nxt_idx, 1'b0};
    else rpr_q <= {{(OUT_W-PRIO_W){1'b0}}, IDLE};
  end

  assign rpr_value = rpr_q;

  // R1: reserved upper bits stay zero
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rpr_value[OUT_W-1:PRIO_W] == '0);

  // R4: any non-idle value has bit 0 clear
  a_r4_bit0_zero: assert property (@(posedge clk) disable iff (rst)
    (rpr_value[PRIO_W-1:0] != IDLE) |-> !rpr_value[0]);

  // R3: after an acknowledge the value is no larger than that entry's group priority
  a_r3_ack_bounds: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> rpr_value[PRIO_W-1:0] <= {$past(ack_lvl), 1'b0});

  // R6: a lone drop never makes the running priority more urgent
  a_r6_drop_monotone: assert property (@(posedge clk) disable iff (rst)
    (drop_valid && !ack_valid) |=> rpr_value[PRIO_W-1:0] >= $past(rpr_value[PRIO_W-1:0]));

  // R8: a lone deactivate leaves the value unchanged
  a_r8_deact_no_effect: assert property (@(posedge clk) disable iff (rst)
    (deact_valid && !ack_valid && !drop_valid) |=> $stable(rpr_value));
endmodule

// File: tb/rpr_tracker_bench.sv
module rpr_tracker_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        ack_valid, drop_valid, deact_valid;
  logic [7:0]  ack_prio;
  logic [3:0]  impl_bits;
  logic [63:0] rpr_value;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rpr_tracker u_rpr_tracker (
    .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_prio(ack_prio),
    .drop_valid(drop_valid), .deact_valid(deact_valid),
    .impl_bits(impl_bits), .rpr_value(rpr_value)
  );

  // Vector: {req[3:0], ack, prio[7:0], drop, deact, cfg[3:0], expected[7:0]}
  localparam int NV = 26;
  localparam logic [26:0] VEC [NV] = '{
    {4'd3,  1'b1, 8'h41, 1'b0, 1'b0, 4'd8,  8'h40}, // R3 first entry
    {4'd3,  1'b1, 8'h80, 1'b0, 1'b0, 4'd8,  8'h40}, // R3 less urgent keeps min
    {4'd4,  1'b1, 8'h11, 1'b0, 1'b0, 4'd8,  8'h10}, // R4 bit0 cleared
    {4'd8,  1'b0, 8'h00, 1'b0, 1'b1, 4'd8,  8'h10}, // R8 deactivate ignored
    {4'd6,  1'b0, 8'h00, 1'b1, 1'b0, 4'd8,  8'h40}, // R6 drop most urgent
    {4'd7,  1'b1, 8'h33, 1'b1, 1'b0, 4'd8,  8'h32}, // R7 drop first, then ack
    {4'd6,  1'b0, 8'h00, 1'b1, 1'b0, 4'd8,  8'h80}, // R6
    {4'd6,  1'b0, 8'h00, 1'b1, 1'b0, 4'd8,  8'hFF}, // R6 all dropped -> idle
    {4'd9,  1'b0, 8'h00, 1'b1, 1'b0, 4'd8,  8'hFF}, // R9 drop on empty
    {4'd5,  1'b1, 8'h5F, 1'b0, 1'b0, 4'd5,  8'h58}, // R5 five bits
    {4'd5,  1'b1, 8'h57, 1'b0, 1'b0, 4'd6,  8'h54}, // R5 six bits
    {4'd5,  1'b1, 8'h53, 1'b0, 1'b0, 4'd7,  8'h52}, // R5 seven bits
    {4'd5,  1'b1, 8'h4F, 1'b0, 1'b0, 4'd2,  8'h48}, // R5 clamp low to 5
    {4'd5,  1'b1, 8'h43, 1'b0, 1'b0, 4'd15, 8'h42}, // R5 clamp high to 8
    {4'd6,  1'b0, 8'h00, 1'b1, 1'b0, 4'd8,  8'h48}, // R6 ordered peel
    {4'd6,  1'b0, 8'h00, 1'b1, 1'b0, 4'd8,  8'h52}, // R6
    {4'd6,  1'b0, 8'h00, 1'b1, 1'b0, 4'd8,  8'h54}, // R6
    {4'd6,  1'b0, 8'h00, 1'b1, 1'b0, 4'd8,  8'h58}, // R6
    {4'd2,  1'b0, 8'h00, 1'b1, 1'b0, 4'd8,  8'hFF}, // R2 idle
    {4'd3,  1'b1, 8'h00, 1'b0, 1'b0, 4'd8,  8'h00}, // R3 most urgent
    {4'd3,  1'b1, 8'hFF, 1'b0, 1'b0, 4'd8,  8'h00}, // R3 least urgent entry
    {4'd4,  1'b0, 8'h00, 1'b1, 1'b0, 4'd8,  8'hFE}, // R4 0xFF prio reads 0xFE
    {4'd2,  1'b0, 8'h00, 1'b1, 1'b0, 4'd8,  8'hFF}, // R2
    {4'd11, 1'b1, 8'h20, 1'b0, 1'b0, 4'd8,  8'h20}, // R11
    {4'd11, 1'b1, 8'h21, 1'b0, 1'b0, 4'd8,  8'h20}, // R11 same level
    {4'd11, 1'b0, 8'h00, 1'b1, 1'b0, 4'd8,  8'hFF}  // R11 one drop empties
  };

  // Every check compares the full 64 bits, so upper-zero (R1) is covered too.
  task automatic check(input int req, input logic [7:0] exp);
    checks++;
    if (rpr_value !== {56'b0, exp}) begin
      errors++;
      $display("FAIL R%0d: rpr_value=%h expected=%h", req, rpr_value, {56'b0, exp});
    end
  endtask

  task automatic step(input logic a, input logic [7:0] p, input logic d,
                      input logic x, input logic [3:0] c);
    @(negedge clk);
    ack_valid = a; ack_prio = p; drop_valid = d; deact_valid = x; impl_bits = c;
    @(posedge clk);
    #5;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; ack_valid = 0; ack_prio = 0; drop_valid = 0; deact_valid = 0;
    impl_bits = 4'd8;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #5;
    check(10, 8'hFF); // R10 reset state is idle
    check(1, 8'hFF);  // R1 upper bits zero after reset

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][22], VEC[i][21:14], VEC[i][13], VEC[i][12], VEC[i][11:8]);
      check(int'(VEC[i][26:23]), VEC[i][7:0]);
    end

    // R10: reset mid-stream empties the running set
    step(1'b1, 8'h10, 1'b0, 1'b0, 4'd8);
    check(3, 8'h10);
    @(negedge clk); rst = 1'b1; ack_valid = 0; drop_valid = 0;
    @(posedge clk); #5;
    check(10, 8'hFF);
    @(negedge clk); rst = 1'b0;
    step(1'b0, 8'h00, 1'b1, 1'b0, 4'd8);
    check(10, 8'hFF); // R10 nothing left to drop after reset

    // R7: ack and drop together with an empty set
    step(1'b1, 8'h64, 1'b1, 1'b0, 4'd8);
    check(7, 8'h64);
    // R8: deactivate alone keeps the running value
    step(1'b0, 8'h00, 1'b0, 1'b1, 4'd8);
    check(8, 8'h64);

    step(1'b0, 8'h00, 1'b0, 1'b0, 4'd8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule